// File: doc/BRIEF.md
# Write-Once Processor Mode Control Register

This block is an 8-bit control register on the processor's internal bus. It answers at one fixed bus address and carries two settings. The first is a two-bit processor mode field. It accepts a single write after reset and then freezes. The second is a stack page select bit, which software may rewrite at any time. The remaining upper bits are not implemented.

Boot code writes the register once, early in the program. That first write fixes the operating mode for the rest of the session. The lock protects the mode field if the program later runs away. The stack page select and the mode field also drive dedicated outputs, so logic elsewhere can use them without a bus read.

Top module: `cpumode_reg`

## Requirements
- R1: After reset the stored value is 0x00: the mode output is 2'b00, the stack page output is 0, and a read returns 0x00.
- R2: The register answers only when the bus address equals 0x3B. A write strobe at any other address changes no stored bit, and a read strobe at any other address returns 0x00 on the read data.
- R3: The first write to 0x3B after reset loads bits 1:0 of the write data into the mode field. Mode code 2'b00 is single-chip mode, and codes 01, 10 and 11 are reserved but still stored.
- R4: The first write to 0x3B after reset sets the lock, whatever value is written. The lock clears only on reset.
- R5: While locked, a write to 0x3B leaves the mode field unchanged.
- R6: Bit 2 of every write to 0x3B sets the stack page select (0 selects page 0, 1 selects page 1). This applies both before and after the lock.
- R7: Write data bits 7:3 are discarded, and read data bits 7:3 are always 0.
- R8: A read strobe at 0x3B returns {5'b0, stack_page, mode} combinationally in the same cycle. A write in that same cycle is visible only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| mode_out | output | 2 | Current processor mode field |
| stack_page_out | output | 1 | Stack page select |

## Verification
The first write is tried with each of the four mode codes, across separate resets. This shows that any code is stored and that the lock does not depend on the value. Locked writes then carry a different mode code together with a toggled bit 2. This separates the frozen mode field from the live stack page bit. Writes and reads at neighbouring addresses (0x3A, 0x3C) and at 0xBB, which differs only in the top bit, show that the full address is compared. Writes with all upper bits set, and a read in the same cycle as a write, confirm the masking and the same-cycle read timing.

// File: rtl/cpumode_pkg.sv
package cpumode_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int MODE_W    = 2;
  localparam int PAGE_BIT  = 2;
  localparam logic [ADDR_W-1:0] REG_ADDR = 8'h3B;

  typedef enum logic [MODE_W-1:0] {
    MODE_SINGLE = 2'b00,
    MODE_RSV1   = 2'b01,
    MODE_RSV2   = 2'b10,
    MODE_RSV3   = 2'b11
  } mode_e;

  function automatic logic [DATA_W-1:0] pack_view(input logic pg, input logic [MODE_W-1:0] m);
    logic [DATA_W-1:0] v;
    v = '0;
    v[MODE_W-1:0] = m;
    v[PAGE_BIT] = pg;
    return v;
  endfunction
endpackage

// File: rtl/cpumode_decode.sv
module cpumode_decode
  import cpumode_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] MATCH = REG_ADDR
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic          hit_wr,
  output logic          hit_rd
);
  logic sel;
  assign sel    = (addr == MATCH);
  assign hit_wr = sel & wr;
  assign hit_rd = sel & rd;
endmodule

// File: rtl/cpumode_lockfield.sv
module cpumode_lockfield
  import cpumode_pkg::*;
#(
  parameter int W = MODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         locked,
  output logic         first_wr
);
  assign first_wr = wr_en & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= '0;
      locked <= 1'b0;
    end else if (first_wr) begin
      value  <= wdata;
      locked <= 1'b1;
    end
  end

  // R5: locked field holds
  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(value));
  // R4: lock never falls outside reset
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R3: first write captures data
  assert_first_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    first_wr |=> (value == $past(wdata)) && locked);
endmodule

// File: rtl/cpumode_reg.sv
module cpumode_reg
  import cpumode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [MODE_W-1:0] mode_out,
  output logic              stack_page_out
);
  logic hit_wr, hit_rd, locked, first_wr, page_q;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] view;

  cpumode_decode #(.AW(ADDR_W), .MATCH(REG_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .hit_wr(hit_wr), .hit_rd(hit_rd));

  cpumode_lockfield #(.W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(hit_wr), .wdata(bus_wdata[MODE_W-1:0]),
    .value(mode_q), .locked(locked), .first_wr(first_wr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= 1'b0;
    else if (hit_wr) page_q <= bus_wdata[PAGE_BIT];
  end

  assign view           = pack_view(page_q, mode_q);
  assign bus_rdata      = hit_rd ? view : '0;
  assign mode_out       = mode_q;
  assign stack_page_out = page_q;

  // R6: page follows every decoded write
  assert_page_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wr |=> stack_page_out == $past(bus_wdata[PAGE_BIT]));
  // R2: no decoded write, no state change
  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_wr |=> $stable(stack_page_out) && $stable(mode_out));
  // R7: upper read bits always zero
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PAGE_BIT+1] == '0);
  // R4: lock follows first decoded write
  assert_lock_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wr |=> locked);
endmodule

// File: tb/tb_cpumode_reg.sv
module tb_cpumode_reg;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic wr = 0, rd = 0;
  logic [1:0] mode;
  logic page;
  int checks = 0, errors = 0;

  cpumode_reg dut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .mode_out(mode), .stack_page_out(page));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr = 0; rd = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  function automatic logic [7:0] bread(input logic [7:0] a);
    return 8'h00;
  endfunction

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a; rd = 1; #1;
    chk(req, rdata, exp);
    rd = 0; #0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mode", {6'b0, mode}, 8'h00);
    chk("R1 page", {7'b0, page}, 8'h00);
    rd_chk("R1 read", 8'h3B, 8'h00);
  endtask

  task automatic t_first_each_code();
    for (int c = 0; c < 4; c++) begin
      do_reset();
      bwrite(8'h3B, 8'(c));
      chk("R3 mode capture", {6'b0, mode}, 8'(c));
      bwrite(8'h3B, 8'(~c) & 8'h03);
      chk("R4 lock after any value", {6'b0, mode}, 8'(c));
    end
  endtask

  task automatic t_locked_page();
    do_reset();
    bwrite(8'h3B, 8'h02);
    bwrite(8'h3B, 8'h05);
    chk("R5 mode frozen", {6'b0, mode}, 8'h02);
    chk("R6 page set after lock", {7'b0, page}, 8'h01);
    rd_chk("R6 read", 8'h3B, 8'h06);
    bwrite(8'h3B, 8'h03);
    chk("R6 page clear after lock", {7'b0, page}, 8'h00);
    chk("R5 mode still frozen", {6'b0, mode}, 8'h02);
  endtask

  task automatic t_decode();
    do_reset();
    bwrite(8'h3A, 8'h07);
    bwrite(8'h3C, 8'h07);
    bwrite(8'hBB, 8'h07);
    chk("R2 stray writes mode", {6'b0, mode}, 8'h00);
    chk("R2 stray writes page", {7'b0, page}, 8'h00);
    bwrite(8'h3B, 8'h01);
    chk("R2 lock not taken by stray", {6'b0, mode}, 8'h01);
    rd_chk("R2 read other addr", 8'h3A, 8'h00);
    rd_chk("R2 read BB", 8'hBB, 8'h00);
  endtask

  task automatic t_mask();
    do_reset();
    bwrite(8'h3B, 8'hFF);
    rd_chk("R7 upper masked", 8'h3B, 8'h07);
    chk("R7 mode", {6'b0, mode}, 8'h03);
  endtask

  task automatic t_same_cycle();
    do_reset();
    addr = 8'h3B; wdata = 8'h06; wr = 1; rd = 1; #1;
    chk("R8 old value same cycle", rdata, 8'h00);
    @(negedge clk); wr = 0; #1;
    chk("R8 new value next cycle", rdata, 8'h06);
    rd = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_each_code();
        t_locked_page();
        t_decode();
        t_mask();
        t_same_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule